// File: doc/BRIEF.md
# Ring-Buffer Page Writer for Device-to-Host Streaming

This block is the device half of a streaming engine that moves 32-bit data words into a ring of host memory pages. Host software programs it through a 32-bit register port. Software loads a table of page bus addresses, sets the burst geometry that makes up one page, and names a host location where progress is posted. It then sets the enable bit. The engine turns each accepted input word into a memory write request. It fills one page at a time in table order and wraps at the end of the table.

The host and the engine share only two indices. The engine posts the bus address of the page it finished most recently, byte-swapped to big-endian order, to the progress location. Software writes back the index of the page it has consumed. The engine never writes into a page that software has not released. When the ring is full it withholds ready on the input stream until software advances its index.

Registers are selected by `reg_addr[5:2]`: 0 control, 1 engine reset, 2 status, 3 page-address load, 4 page count, 5 last-consumed index, 6 words per burst, 7 bursts per page, 8 progress interval, 9 progress base address.

Top module: `pkt_ring_dma`

## Requirements
- R1: Control bit 0 enables the engine. While it is clear, or while the page table is empty, `in_ready` stays low and no input word is taken. Control bit 1 selects 64-bit progress mode.
- R2: Writing 1 to the reset register holds the engine in reset: `in_ready` is low, any queued request is dropped and the enable bit reads back 0. Writing 0 releases the engine. A read of the reset register returns 0x14031700 while `link_up` is high and 0 otherwise.
- R3: Each write to the page-address register stores its value in the next free table slot. Writes made after all slots are full are ignored. A read of page count returns the number of loaded pages minus one, so it reads 0xFFFFFFFF when the table is empty. Writing 0 to page count empties the table.
- R4: A page-address write whose low 12 bits are not all zero sets status bit 0. Emptying the table clears that bit.
- R5: Accepted words are written in order to consecutive 32-bit locations of the current page, starting at its base address. A page holds (words per burst × bursts per page) words. After the last word of a page, the engine moves to the next table entry and wraps after the last loaded page.
- R6: Setting the enable bit first posts the value 0 to the progress location. Filling then starts at the page after the last-consumed index.
- R7: After every N completed pages, where N is the progress interval, the engine posts the bus address of the page just completed, byte-reversed (bits 7:0 moved to 31:24 and so on). The target is the progress base plus 16 in 32-bit mode, or plus 12 in 64-bit mode.
- R8: A write of v to the last-consumed register marks page v as released. A value equal to the number of loaded pages is taken as page 0, and the register then reads back 0.
- R9: `in_ready` is high only when the page to be filled differs from the last-consumed index. When software advances the index, filling resumes.
- R10: Once `mw_valid` is raised, `mw_addr` and `mw_data` stay unchanged until `mw_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Link is ready; selects the reset-register readback signature |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input data word |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| mw_valid | output | 1 | Memory write request valid |
| mw_addr | output | 32 | Memory write byte address |
| mw_data | output | 32 | Memory write data |
| mw_ready | input | 1 | Memory write request taken |

## Verification
The bench builds the block with a four-slot page table. A fifth page-address write therefore lands on a full table, and the ring wraps and fills within a few dozen words. Pages of four words (two bursts of two) make the word-to-address mapping and the page boundaries show up quickly. Two runs use progress intervals of 1 and 2. They cover both progress offsets, the start point implied by an acknowledged index equal to the ring size, and a stalling memory port that keeps requests held.

// File: rtl/dma_ring_pkg.sv
// Shared constants, register selector codes and helpers for the page ring writer.
package dma_ring_pkg;

    // Value returned by the reset register while the link reports ready.
    localparam logic [31:0] LINK_SIGNATURE = 32'h1403_1700;

    // Offset of the progress word from its base, per addressing mode.
    localparam logic [31:0] PROG_OFF_32 = 32'd16;
    localparam logic [31:0] PROG_OFF_64 = 32'd12;

    // Register selector, taken from reg_addr[5:2].
    typedef enum logic [3:0] {
        RG_CTRL        = 4'd0,
        RG_RESET       = 4'd1,
        RG_STATUS      = 4'd2,
        RG_PAGE_ADDR   = 4'd3,
        RG_PAGE_COUNT  = 4'd4,
        RG_ACK         = 4'd5,
        RG_BURST_WORDS = 4'd6,
        RG_BURST_COUNT = 4'd7,
        RG_INTERVAL    = 4'd8,
        RG_PROG_BASE   = 4'd9
    } reg_sel_e;

    // Reverse the byte order of a 32-bit word.
    function automatic logic [31:0] swap_bytes(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/dma_ring_regs.sv
// Register file of the page ring writer.
// Decodes single-cycle register writes, holds configuration, the
// last-consumed index, the engine reset and the misalignment flag, and
// produces the combinational read data. Assumes one access per cycle.
module dma_ring_regs
    import dma_ring_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             link_up,
    input  logic [CNT_W-1:0] page_count,
    output logic             enable,
    output logic             mode64,
    output logic             soft_rst,
    output logic             start,
    output logic             tbl_load,
    output logic             tbl_clear,
    output logic             misalign_err,
    output logic [IDX_W-1:0] ack_idx,
    output logic [31:0]      burst_words,
    output logic [31:0]      burst_count,
    output logic [31:0]      interval,
    output logic [31:0]      prog_base
);

    logic wr_ctrl;
    logic wr_ack;

    // Write strobes per register.
    assign wr_ctrl   = reg_wr && (reg_sel == RG_CTRL);
    assign wr_ack    = reg_wr && (reg_sel == RG_ACK);
    assign tbl_load  = reg_wr && (reg_sel == RG_PAGE_ADDR);
    assign tbl_clear = reg_wr && (reg_sel == RG_PAGE_COUNT) && (reg_wdata == 32'd0);

    // One-cycle pulse when the enable bit goes from clear to set.
    assign start = wr_ctrl && reg_wdata[0] && !enable && !soft_rst;

    // Configuration, control and status state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable       <= 1'b0;
            mode64       <= 1'b0;
            soft_rst     <= 1'b0;
            misalign_err <= 1'b0;
            ack_idx      <= '0;
            burst_words  <= 32'd1;
            burst_count  <= 32'd1;
            interval     <= 32'd1;
            prog_base    <= 32'd0;
        end else begin
            if (soft_rst) begin
                enable <= 1'b0;
            end else if (wr_ctrl) begin
                enable <= reg_wdata[0];
            end
            if (wr_ctrl) begin
                mode64 <= reg_wdata[1];
            end
            if (reg_wr && (reg_sel == RG_RESET)) begin
                soft_rst <= reg_wdata[0];
            end
            if (tbl_clear) begin
                misalign_err <= 1'b0;
            end else if (tbl_load && (reg_wdata[11:0] != 12'd0)) begin
                misalign_err <= 1'b1;
            end
            if (wr_ack) begin
                ack_idx <= (reg_wdata == 32'(page_count)) ? '0 : reg_wdata[IDX_W-1:0];
            end
            if (reg_wr && (reg_sel == RG_BURST_WORDS)) burst_words <= reg_wdata;
            if (reg_wr && (reg_sel == RG_BURST_COUNT)) burst_count <= reg_wdata;
            if (reg_wr && (reg_sel == RG_INTERVAL))    interval    <= reg_wdata;
            if (reg_wr && (reg_sel == RG_PROG_BASE))   prog_base   <= reg_wdata;
        end
    end

    // Read data multiplexer.
    always_comb begin
        case (reg_sel_e'(reg_sel))
            RG_CTRL:        reg_rdata = {30'd0, mode64, enable};
            RG_RESET:       reg_rdata = link_up ? LINK_SIGNATURE : 32'd0;
            RG_STATUS:      reg_rdata = {31'd0, misalign_err};
            RG_PAGE_COUNT:  reg_rdata = 32'(page_count) - 32'd1;
            RG_ACK:         reg_rdata = 32'(ack_idx);
            RG_BURST_WORDS: reg_rdata = burst_words;
            RG_BURST_COUNT: reg_rdata = burst_count;
            RG_INTERVAL:    reg_rdata = interval;
            RG_PROG_BASE:   reg_rdata = prog_base;
            default:        reg_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/dma_ring_page_table.sv
// Page address table of the page ring writer.
// Appends one bus address per load strobe until all DEPTH slots are used.
// Further loads are ignored. A clear strobe empties the table. Provides
// one combinational read port indexed by slot.
module dma_ring_page_table #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [31:0]      load_addr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_addr,
    output logic [CNT_W-1:0] count
);

    logic [31:0] slot [DEPTH];
    logic        room;

    assign room = (count < CNT_W'(DEPTH));

    // Number of loaded slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (load && room) begin
            count <= count + 1'b1;
        end
    end

    // One storage register per slot, written when it is the next free one.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= 32'd0;
            end else if (load && !clear && (count == CNT_W'(g))) begin
                slot[g] <= load_addr;
            end
        end
    end

    // Read port; an index past the array returns zero.
    assign rd_addr = (32'(rd_idx) < DEPTH) ? slot[rd_idx] : 32'd0;

endmodule

// File: rtl/dma_ring_fill.sv
// Fill engine of the page ring writer.
// Turns accepted input words into memory write requests at consecutive
// addresses of the current page and advances through the ring. It stops
// at the last-consumed page and posts progress words. A single output
// register holds each request until the memory side takes it. Assumes
// configuration is stable while the engine is enabled.
module dma_ring_fill
    import dma_ring_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             enable,
    input  logic             mode64,
    input  logic             start,
    input  logic [IDX_W-1:0] ack_idx,
    input  logic [CNT_W-1:0] page_count,
    input  logic [31:0]      page_addr,
    input  logic [31:0]      burst_words,
    input  logic [31:0]      burst_count,
    input  logic [31:0]      interval,
    input  logic [31:0]      prog_base,
    output logic [IDX_W-1:0] fill_idx,
    input  logic             in_valid,
    input  logic [31:0]      in_data,
    output logic             in_ready,
    output logic             mw_valid,
    output logic [31:0]      mw_addr,
    output logic [31:0]      mw_data,
    input  logic             mw_ready
);

    logic [31:0] word_cnt;
    logic [31:0] burst_cnt;
    logic [31:0] byte_off;
    logic [31:0] done_cnt;
    logic        wb_pend;
    logic [31:0] wb_data;
    logic [31:0] words_eff, bursts_eff, interval_eff;
    logic        running, ring_full, can_load, accept;
    logic        last_word, last_burst;
    logic [31:0] prog_addr;

    // Next ring index, wrapping after the last loaded page.
    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i,
                                              input logic [CNT_W-1:0] n);
        return ((CNT_W'(i) + 1'b1) >= n) ? '0 : i + 1'b1;
    endfunction

    // Zero-valued geometry fields act as one so that pages always end.
    assign words_eff    = (burst_words == 32'd0) ? 32'd1 : burst_words;
    assign bursts_eff   = (burst_count == 32'd0) ? 32'd1 : burst_count;
    assign interval_eff = (interval    == 32'd0) ? 32'd1 : interval;

    assign running    = enable && !soft_rst && (page_count != '0);
    assign ring_full  = (fill_idx == ack_idx);
    assign can_load   = !mw_valid || mw_ready;
    assign in_ready   = running && !ring_full && !wb_pend && can_load;
    assign accept     = in_valid && in_ready;
    assign last_word  = (word_cnt == words_eff - 32'd1);
    assign last_burst = (burst_cnt == bursts_eff - 32'd1);
    assign prog_addr  = prog_base + (mode64 ? PROG_OFF_64 : PROG_OFF_32);

    // Ring position, page geometry counters, progress posting and output register.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            fill_idx  <= '0;
            word_cnt  <= 32'd0;
            burst_cnt <= 32'd0;
            byte_off  <= 32'd0;
            done_cnt  <= 32'd0;
            wb_pend   <= 1'b0;
            wb_data   <= 32'd0;
            mw_valid  <= 1'b0;
            mw_addr   <= 32'd0;
            mw_data   <= 32'd0;
        end else begin
            if (mw_valid && mw_ready) begin
                mw_valid <= 1'b0;
            end
            if (start) begin
                fill_idx  <= step(ack_idx, page_count);
                word_cnt  <= 32'd0;
                burst_cnt <= 32'd0;
                byte_off  <= 32'd0;
                done_cnt  <= 32'd0;
                wb_pend   <= 1'b1;
                wb_data   <= 32'd0;
            end else if (accept) begin
                mw_valid <= 1'b1;
                mw_addr  <= page_addr + byte_off;
                mw_data  <= in_data;
                if (!last_word) begin
                    word_cnt <= word_cnt + 32'd1;
                    byte_off <= byte_off + 32'd4;
                end else if (!last_burst) begin
                    word_cnt  <= 32'd0;
                    burst_cnt <= burst_cnt + 32'd1;
                    byte_off  <= byte_off + 32'd4;
                end else begin
                    word_cnt  <= 32'd0;
                    burst_cnt <= 32'd0;
                    byte_off  <= 32'd0;
                    fill_idx  <= step(fill_idx, page_count);
                    if (done_cnt + 32'd1 >= interval_eff) begin
                        done_cnt <= 32'd0;
                        wb_pend  <= 1'b1;
                        wb_data  <= swap_bytes(page_addr);
                    end else begin
                        done_cnt <= done_cnt + 32'd1;
                    end
                end
            end else if (wb_pend && can_load) begin
                mw_valid <= 1'b1;
                mw_addr  <= prog_addr;
                mw_data  <= wb_data;
                wb_pend  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pkt_ring_dma.sv
// Top of the page ring writer: register file, page table and fill engine.
// Assumes a single clock and a synchronous active-low reset. The page
// table depth is MAX_PAGES (at least 2).
module pkt_ring_dma #(
    parameter int MAX_PAGES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_up,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        mw_valid,
    output logic [31:0] mw_addr,
    output logic [31:0] mw_data,
    input  logic        mw_ready
);

    localparam int IDX_W = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1;
    localparam int CNT_W = $clog2(MAX_PAGES + 1);

    logic             enable, mode64, soft_rst, start;
    logic             tbl_load, tbl_clear, misalign_err;
    logic [IDX_W-1:0] ack_idx, fill_idx;
    logic [CNT_W-1:0] page_count;
    logic [31:0]      burst_words, burst_count, interval, prog_base, page_addr;

    dma_ring_regs #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_sel      (reg_addr[5:2]),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .link_up      (link_up),
        .page_count   (page_count),
        .enable       (enable),
        .mode64       (mode64),
        .soft_rst     (soft_rst),
        .start        (start),
        .tbl_load     (tbl_load),
        .tbl_clear    (tbl_clear),
        .misalign_err (misalign_err),
        .ack_idx      (ack_idx),
        .burst_words  (burst_words),
        .burst_count  (burst_count),
        .interval     (interval),
        .prog_base    (prog_base)
    );

    dma_ring_page_table #(.DEPTH(MAX_PAGES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tbl_load),
        .clear     (tbl_clear),
        .load_addr (reg_wdata),
        .rd_idx    (fill_idx),
        .rd_addr   (page_addr),
        .count     (page_count)
    );

    dma_ring_fill #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .enable      (enable),
        .mode64      (mode64),
        .start       (start),
        .ack_idx     (ack_idx),
        .page_count  (page_count),
        .page_addr   (page_addr),
        .burst_words (burst_words),
        .burst_count (burst_count),
        .interval    (interval),
        .prog_base   (prog_base),
        .fill_idx    (fill_idx),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .mw_valid    (mw_valid),
        .mw_addr     (mw_addr),
        .mw_data     (mw_data),
        .mw_ready    (mw_ready)
    );

endmodule

// File: rtl/dma_ring_chk.sv
// Property checker for the page ring writer, bound into its top module.
module dma_ring_chk
    import dma_ring_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             soft_rst,
    input logic             misalign_err,
    input logic [IDX_W-1:0] fill_idx,
    input logic [IDX_W-1:0] ack_idx,
    input logic             link_up,
    input logic             reg_wr,
    input logic [5:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             in_ready,
    input logic             mw_valid,
    input logic             mw_ready,
    input logic [31:0]      mw_addr,
    input logic [31:0]      mw_data
);

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !in_ready);

    assert_hold_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !in_ready);

    assert_signature_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[5:2] == 4'd1 && link_up) |-> (reg_rdata == LINK_SIGNATURE));

    assert_misalign_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[5:2] == 4'd3 && reg_wdata[11:0] != 12'd0) |=> misalign_err);

    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (fill_idx != ack_idx));

    assert_request_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ready && !soft_rst) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

endmodule

bind pkt_ring_dma dma_ring_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .soft_rst     (soft_rst),
    .misalign_err (misalign_err),
    .fill_idx     (fill_idx),
    .ack_idx      (ack_idx),
    .link_up      (link_up),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .in_ready     (in_ready),
    .mw_valid     (mw_valid),
    .mw_ready     (mw_ready),
    .mw_addr      (mw_addr),
    .mw_data      (mw_data)
);

// File: tb/sim_pkt_ring_dma.sv
// Bench: behavioural ring model with an expected-write queue, compared every cycle.
module sim_pkt_ring_dma;

    localparam int PAGES = 4;
    localparam logic [3:0] S_CTRL = 4'd0, S_RESET = 4'd1, S_STATUS = 4'd2, S_PADDR = 4'd3,
                           S_PCOUNT = 4'd4, S_ACK = 4'd5, S_BWORDS = 4'd6, S_BCOUNT = 4'd7,
                           S_INTERVAL = 4'd8, S_PROG = 4'd9;

    logic        clk = 1'b0, rst_n = 1'b0, link_up = 1'b0, reg_wr = 1'b0;
    logic [5:0]  reg_addr = 6'd0;
    logic [31:0] reg_wdata = 32'd0, reg_rdata;
    logic        in_valid = 1'b0, in_ready, mw_valid, mw_ready = 1'b1;
    logic [31:0] in_data = 32'hC0DE_0000, mw_addr, mw_data;

    pkt_ring_dma #(.MAX_PAGES(PAGES)) u0 (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data),
        .mw_ready(mw_ready)
    );

    always #2.5ns clk = ~clk;

    int n_checks = 0, n_fail = 0, wd_cnt = 0, cyc = 0, acc_cnt = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Reference model state
    logic [31:0] m_pages [PAGES];
    int          m_n = 0, m_l = 0, m_w = 0, m_off = 0, m_done = 0, m_pw = 1, m_thr = 1;
    bit          m_en = 0, m_mode64 = 0;
    logic [31:0] m_prog = 32'd0;
    logic [63:0] expq [$];
    string       tagq [$];

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] prog_target();
        return m_prog + (m_mode64 ? 32'd12 : 32'd16);
    endfunction

    function automatic void model_start();
        m_en   = 1;
        m_w    = (m_l + 1) % m_n;
        m_off  = 0;
        m_done = 0;
        expq.push_back({prog_target(), 32'd0});
        tagq.push_back("R6 clear progress on enable");
    endfunction

    function automatic void model_accept(input logic [31:0] d);
        expq.push_back({m_pages[m_w] + 32'(m_off * 4), d});
        tagq.push_back("R5 page data write");
        m_off++;
        if (m_off == m_pw) begin
            m_off = 0;
            m_done++;
            if (m_done == m_thr) begin
                expq.push_back({prog_target(), bswap(m_pages[m_w])});
                tagq.push_back("R7 progress post");
                m_done = 0;
            end
            m_w = (m_w + 1) % m_n;
        end
    endfunction

    bit stream_on = 0, slow_ready = 0, last_acc = 0, hold_p = 0, rst_note = 0;
    logic [31:0] p_a = 32'd0, p_d = 32'd0;

    // Stream driver at the falling edge; monitor and model just before the rising edge.
    always @(negedge clk) begin
        if (last_acc) in_data = in_data + 32'h0001_0003;
        in_valid = stream_on;
        mw_ready = !slow_ready || (cyc % 3 != 2);
        #2ns;
        cyc++;
        if (rst_n) begin
            if (hold_p && !rst_note)
                check(mw_valid && mw_addr == p_a && mw_data == p_d, "R10 held request",
                      {mw_addr, mw_data}, {p_a, p_d});
            if (mw_valid && mw_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R5 unexpected memory write", {mw_addr, mw_data}, 64'd0);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check({mw_addr, mw_data} == e, t, {mw_addr, mw_data}, e);
                end
            end
            if (in_ready)
                check(m_en && (m_w != m_l), "R9 ready only with a free page",
                      64'(m_w), 64'(m_l));
            last_acc = in_valid && in_ready;
            if (last_acc) begin
                acc_cnt++;
                model_accept(in_data);
            end
            hold_p = mw_valid && !mw_ready;
            p_a = mw_addr;
            p_d = mw_data;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt == 30000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<30000 cycles", wd_cnt);
            summary();
            $finish;
        end
    end

    task automatic reg_write(input logic [3:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = {sel, 2'b00};
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_addr = {sel, 2'b00};
        #1ns;
        d = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1ns;
        check(in_ready == 1'b0, "R1 no ready after reset", 64'(in_ready), 64'd0);
        reg_read(S_PCOUNT, v);
        check(v == 32'hFFFF_FFFF, "R3 empty table count", 64'(v), 64'hFFFF_FFFF);
        reg_read(S_RESET, v);
        check(v == 32'd0, "R2 reset read without link", 64'(v), 64'd0);
        @(negedge clk);
        link_up = 1'b1;
        reg_read(S_RESET, v);
        check(v == 32'h1403_1700, "R2 link signature", 64'(v), 64'h1403_1700);

        // Misaligned load flags status, table clear removes flag and entries.
        reg_write(S_PADDR, 32'h0000_1004);
        reg_read(S_STATUS, v);
        check(v == 32'd1, "R4 misaligned flag set", 64'(v), 64'd1);
        reg_read(S_PCOUNT, v);
        check(v == 32'd0, "R3 one page loaded", 64'(v), 64'd0);
        reg_write(S_PCOUNT, 32'd0);
        reg_read(S_STATUS, v);
        check(v == 32'd0, "R4 flag cleared with table", 64'(v), 64'd0);
        reg_read(S_PCOUNT, v);
        check(v == 32'hFFFF_FFFF, "R3 table emptied", 64'(v), 64'hFFFF_FFFF);

        // Load the ring; the fifth write lands on a full table.
        m_pages[0] = 32'h1234_5000;
        m_pages[1] = 32'h0ABC_D000;
        m_pages[2] = 32'h0077_7000;
        m_pages[3] = 32'hFEDC_B000;
        for (int i = 0; i < PAGES; i++) reg_write(S_PADDR, m_pages[i]);
        reg_write(S_PADDR, 32'h9999_9000);
        reg_read(S_PCOUNT, v);
        check(v == 32'd3, "R3 extra load ignored", 64'(v), 64'd3);
        reg_read(S_STATUS, v);
        check(v == 32'd0, "R4 aligned loads leave flag clear", 64'(v), 64'd0);

        // Run 1: pages of 2x2 words, progress every page, 32-bit mode, start at page 0.
        reg_write(S_BWORDS, 32'd2);
        reg_write(S_BCOUNT, 32'd2);
        reg_write(S_INTERVAL, 32'd1);
        reg_write(S_PROG, 32'h0000_8000);
        reg_write(S_ACK, 32'd3);
        m_n = PAGES; m_pw = 4; m_thr = 1; m_prog = 32'h0000_8000; m_mode64 = 0; m_l = 3;
        @(posedge clk);
        stream_on = 1;
        repeat (6) @(negedge clk);
        check(acc_cnt == 0, "R1 no intake while disabled", 64'(acc_cnt), 64'd0);
        reg_write(S_CTRL, 32'd1);
        model_start();
        repeat (80) @(negedge clk);
        #1ns;
        check(acc_cnt == 12, "R9 stops one page short of last consumed", 64'(acc_cnt), 64'd12);
        check(in_ready == 1'b0, "R9 ready low when full", 64'(in_ready), 64'd0);
        check(expq.size() == 0, "R5 all run 1 writes seen", 64'(expq.size()), 64'd0);
        reg_write(S_ACK, 32'd0);
        m_l = 0;
        repeat (40) @(negedge clk);
        #1ns;
        check(acc_cnt == 16, "R9 resumes after release", 64'(acc_cnt), 64'd16);
        check(expq.size() == 0, "R7 wrap page posted", 64'(expq.size()), 64'd0);

        // Engine reset.
        @(posedge clk);
        stream_on = 0;
        rst_note  = 1;
        reg_write(S_RESET, 32'd1);
        m_en = 0;
        repeat (3) @(negedge clk);
        #1ns;
        check(in_ready == 1'b0, "R2 ready low in engine reset", 64'(in_ready), 64'd0);
        reg_read(S_CTRL, v);
        check(v[0] == 1'b0, "R2 enable cleared by engine reset", 64'(v), 64'd0);
        reg_write(S_RESET, 32'd0);
        @(posedge clk);
        rst_note = 0;

        // Run 2: 64-bit mode, progress every two pages, ack equal to ring size means page 0.
        reg_write(S_INTERVAL, 32'd2);
        reg_write(S_ACK, 32'd4);
        m_l = 0;
        reg_read(S_ACK, v);
        check(v == 32'd0, "R8 ring-size ack reads as 0", 64'(v), 64'd0);
        m_thr = 2; m_mode64 = 1;
        @(posedge clk);
        slow_ready = 1;
        stream_on  = 1;
        reg_write(S_CTRL, 32'd3);
        model_start();
        repeat (100) @(negedge clk);
        #1ns;
        check(acc_cnt == 28, "R6 fill starts after last consumed page", 64'(acc_cnt), 64'd28);
        check(in_ready == 1'b0, "R9 full in run 2", 64'(in_ready), 64'd0);
        check(expq.size() == 0, "R7 run 2 writes seen", 64'(expq.size()), 64'd0);
        reg_write(S_ACK, 32'd1);
        m_l = 1;
        repeat (60) @(negedge clk);
        #1ns;
        check(acc_cnt == 32, "R9 run 2 resumes", 64'(acc_cnt), 64'd32);
        check(expq.size() == 0, "R7 interval post after second page", 64'(expq.size()), 64'd0);

        summary();
        $finish;
    end

endmodule